// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wakeup

This block is a relative alarm timer for a real-time clock. Software writes an unsigned interval in seconds. The interval is copied straight into a down-counter. While counting is enabled, each one-cycle second tick lowers the counter by one. When the counter reaches zero, a sticky pending flag is set. The interrupt line is the pending flag gated by an interrupt enable. The wakeup line is the same flag gated by a separate wakeup enable. Software clears the flag by writing a one to it.

Access is through a simple single-cycle register port. A write is taken at the clock edge that ends the cycle in which `wr_en` is high. Reads are combinational from `addr`. A second sticky flag records hits of an external weekly alarm. It has its own write-one-to-clear status location and has no effect on the outputs.

Top module: `cd_alarm_top`

## Requirements
- R1: After reset every readable location returns 0, and `irq_o` and `wake_o` are 0.
- R2: A write to offset 0x20 loads the value into the current count, which is read at offset 0x24, at the same edge. Offset 0x20 reads back the last value loaded.
- R3: While bit 0 of offset 0x28 is 1 and the count is non-zero, each `sec_tick` lowers the count by exactly one. While that bit is 0, the count holds.
- R4: A tick that takes the count from 1 to 0 sets the pending flag (bit 0 of offset 0x30) at that edge. A count of zero stays at zero under further ticks.
- R5: Loading 0 never sets the pending flag, whatever ticks follow.
- R6: Writing 1 to bit 0 of offset 0x30 clears the pending flag, and writing 0 there leaves it unchanged. If an expiry happens in the same cycle as the clear, the flag stays set.
- R7: `irq_o` equals the pending flag AND bit 0 of offset 0x2C.
- R8: `wake_o` equals the pending flag AND bit 0 of offset 0x50.
- R9: A `week_hit_i` pulse sets bit 0 of offset 0x4C. Writing 1 to that bit clears it. Clearing one status location does not touch the other.
- R10: A load write in the same cycle as a tick takes priority: the count becomes the written value.
- R11: Reads of offsets not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data for `addr` |
| sec_tick | input | 1 | One-cycle pulse per second |
| week_hit_i | input | 1 | Weekly alarm hit pulse |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
Every register write, load and tick takes effect at the single rising edge that ends the cycle in which it is driven. A tick that empties the counter sets the pending flag at that same edge. `irq_o` and `wake_o` follow the flag and enables with no extra register. Read data is combinational. The bench drives every stimulus just after a falling edge and holds it for one full cycle. It then reads back one nanosecond after the next falling edge, so each result is sampled exactly one edge after its cause and never near a rising edge.

// File: rtl/cd_alarm_pkg.sv
package cd_alarm_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_LOAD = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CUR  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_RUN  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_STA  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_WSTA = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_WAKE = 8'h50;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_LOAD, SEL_CUR, SEL_RUN,
        SEL_IEN, SEL_STA, SEL_WSTA, SEL_WAKE
    } sel_e;

    typedef struct packed {
        logic run;
        logic irq_en;
        logic wake_en;
    } ctrl_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_LOAD: return SEL_LOAD;
            OFF_CUR:  return SEL_CUR;
            OFF_RUN:  return SEL_RUN;
            OFF_IEN:  return SEL_IEN;
            OFF_STA:  return SEL_STA;
            OFF_WSTA: return SEL_WSTA;
            OFF_WAKE: return SEL_WAKE;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cd_ctrl_regs.sv
module cd_ctrl_regs
    import cd_alarm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  sel_e  sel,
    input  logic  bit0,
    output ctrl_t ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we) begin
            case (sel)
                SEL_RUN:  ctrl.run     <= bit0;
                SEL_IEN:  ctrl.irq_en  <= bit0;
                SEL_WAKE: ctrl.wake_en <= bit0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cd_down_counter.sv
module cd_down_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         run,
    output logic [W-1:0] count,
    output logic [W-1:0] shadow,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;
    assign step   = tick && run && (count != '0) && !load;
    assign expire = step && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            shadow <= '0;
        end else if (load) begin
            count  <= load_val;
            shadow <= load_val;
        end else if (step) begin
            count  <= count - ONE;
        end
    end
endmodule

// File: rtl/cd_sticky_flag.sv
module cd_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/cd_alarm_top.sv
module cd_alarm_top
    import cd_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              sec_tick,
    input  logic              week_hit_i,
    output logic              irq_o,
    output logic              wake_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    sel_e             sel;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] load_shadow;
    logic             expire;
    logic             pend;
    logic             week_pend;
    logic             load_wr;
    logic             sta_clr;
    logic             wsta_clr;

    assign sel      = decode(addr);
    assign load_wr  = wr_en && (sel == SEL_LOAD);
    assign sta_clr  = wr_en && (sel == SEL_STA)  && wdata[0];
    assign wsta_clr = wr_en && (sel == SEL_WSTA) && wdata[0];

    cd_ctrl_regs u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .sel  (sel),
        .bit0 (wdata[0]),
        .ctrl (ctrl)
    );

    cd_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_wr),
        .load_val (wdata),
        .tick     (sec_tick),
        .run      (ctrl.run),
        .count    (cur_cnt),
        .shadow   (load_shadow),
        .expire   (expire)
    );

    cd_sticky_flag u_pend (
        .clk (clk),
        .rst (rst),
        .set (expire),
        .clr (sta_clr),
        .q   (pend)
    );

    cd_sticky_flag u_week (
        .clk (clk),
        .rst (rst),
        .set (week_hit_i),
        .clr (wsta_clr),
        .q   (week_pend)
    );

    assign irq_o  = pend && ctrl.irq_en;
    assign wake_o = pend && ctrl.wake_en;

    always_comb begin
        rdata = ZERO;
        case (sel)
            SEL_LOAD: rdata = load_shadow;
            SEL_CUR:  rdata = cur_cnt;
            SEL_RUN:  rdata[0] = ctrl.run;
            SEL_IEN:  rdata[0] = ctrl.irq_en;
            SEL_STA:  rdata[0] = pend;
            SEL_WSTA: rdata[0] = week_pend;
            SEL_WAKE: rdata[0] = ctrl.wake_en;
            default:  rdata = ZERO;
        endcase
    end
endmodule

// File: rtl/cd_alarm_chk.sv
module cd_alarm_chk
    import cd_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              sec_tick,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              pend,
    input logic              irq,
    input logic              wake
);
    logic ld;
    logic clr;
    assign ld  = wr_en && (addr == OFF_LOAD);
    assign clr = wr_en && (addr == OFF_STA) && wdata[0];

    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        ld |=> cnt == $past(wdata));

    a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && sec_tick && run && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ld && !run) |=> $stable(cnt));

    a_r4_expire_sets: assert property (@(posedge clk) disable iff (rst)
        (!ld && sec_tick && run && cnt == CNT_W'(1)) |=> pend);

    a_r5_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (!ld && cnt == '0) |=> cnt == '0);

    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr && !(sec_tick && run && !ld && cnt == CNT_W'(1))) |=> !pend);

    a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend);

    a_r8_wake_needs_pend: assert property (@(posedge clk) disable iff (rst)
        wake |-> pend);
endmodule

bind cd_alarm_top cd_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .sec_tick (sec_tick),
    .cnt      (cur_cnt),
    .run      (ctrl.run),
    .pend     (pend),
    .irq      (irq_o),
    .wake     (wake_o)
);

// File: tb/cd_alarm_top_tb_top.sv
module cd_alarm_top_tb_top;
    import cd_alarm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sec_tick = 1'b0;
    logic        week_hit_i = 1'b0;
    logic        irq_o;
    logic        wake_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cd_alarm_top #(.CNT_W(32)) dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .sec_tick (sec_tick),
        .week_hit_i (week_hit_i), .irq_o (irq_o), .wake_o (wake_o)
    );

    // {load value, tick count, expected count, expected pending}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV][4] = '{
        '{32'd5,         32'd3, 32'd2,         32'd0},
        '{32'd5,         32'd5, 32'd0,         32'd1},
        '{32'd1,         32'd1, 32'd0,         32'd1},
        '{32'd0,         32'd4, 32'd0,         32'd0},
        '{32'd3,         32'd7, 32'd0,         32'd1},
        '{32'hFFFF_FFFF, 32'd2, 32'hFFFF_FFFD, 32'd0},
        '{32'd12,        32'd0, 32'd12,        32'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(OFF_LOAD, v); check("R1 load", v, 0);
        rd(OFF_CUR, v);  check("R1 cur", v, 0);
        rd(OFF_RUN, v);  check("R1 run", v, 0);
        rd(OFF_IEN, v);  check("R1 ien", v, 0);
        rd(OFF_STA, v);  check("R1 sta", v, 0);
        rd(OFF_WSTA, v); check("R1 wsta", v, 0);
        rd(OFF_WAKE, v); check("R1 wake cfg", v, 0);
        check("R1 irq", {31'd0, irq_o}, 0);
        check("R1 wake", {31'd0, wake_o}, 0);

        // R3 disabled hold
        wr(OFF_LOAD, 32'd4);
        ticks(3);
        rd(OFF_CUR, v); check("R3 hold while stopped", v, 4);

        // vector table: R2 R3 R4 R5
        wr(OFF_RUN, 32'd1);
        for (int k = 0; k < NV; k++) begin
            wr(OFF_STA, 32'd1);
            wr(OFF_LOAD, VEC[k][0]);
            rd(OFF_LOAD, v); check("R2 load readback", v, VEC[k][0]);
            ticks(int'(VEC[k][1]));
            rd(OFF_CUR, v); check("R3 R4 R5 count", v, VEC[k][2]);
            rd(OFF_STA, v); check("R4 R5 pending", v, VEC[k][3]);
        end

        // R7 R8 gating
        wr(OFF_STA, 32'd1);
        wr(OFF_IEN, 32'd1);
        wr(OFF_LOAD, 32'd2);
        ticks(2);
        check("R7 irq on", {31'd0, irq_o}, 1);
        check("R8 wake off", {31'd0, wake_o}, 0);
        wr(OFF_WAKE, 32'd1);
        check("R8 wake on", {31'd0, wake_o}, 1);
        wr(OFF_IEN, 32'd0);
        check("R7 irq gated", {31'd0, irq_o}, 0);

        // R6 write 0 no effect, write 1 clears
        wr(OFF_STA, 32'd0);
        rd(OFF_STA, v); check("R6 zero write keeps", v, 1);
        wr(OFF_STA, 32'd1);
        rd(OFF_STA, v); check("R6 clear", v, 0);
        check("R8 wake drops", {31'd0, wake_o}, 0);

        // R6 set wins over clear
        wr(OFF_LOAD, 32'd1);
        @(negedge clk);
        wr_en = 1'b1; addr = OFF_STA; wdata = 32'd1; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; sec_tick = 1'b0;
        rd(OFF_STA, v); check("R6 set over clear", v, 1);
        wr(OFF_STA, 32'd1);

        // R10 load beats tick
        wr(OFF_LOAD, 32'd7);
        @(negedge clk);
        wr_en = 1'b1; addr = OFF_LOAD; wdata = 32'd9; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; sec_tick = 1'b0;
        rd(OFF_CUR, v); check("R10 load priority", v, 9);

        // R9 weekly flag
        @(negedge clk); week_hit_i = 1'b1;
        @(negedge clk); week_hit_i = 1'b0;
        rd(OFF_WSTA, v); check("R9 week set", v, 1);
        wr(OFF_LOAD, 32'd1);
        ticks(1);
        wr(OFF_WSTA, 32'd1);
        rd(OFF_WSTA, v); check("R9 week clear", v, 0);
        rd(OFF_STA, v);  check("R9 alarm untouched", v, 1);
        wr(OFF_STA, 32'd1);
        @(negedge clk); week_hit_i = 1'b1;
        @(negedge clk); week_hit_i = 1'b0;
        rd(OFF_WSTA, v); check("R9 week kept", v, 1);

        // R11 unmapped
        rd(8'h44, v); check("R11 unmapped 0x44", v, 0);
        rd(8'h00, v); check("R11 unmapped 0x00", v, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule